// File: doc/BRIEF.md
# Codec Register Access Controller for a Serial Audio Link

This block sits between a host register port and the builder of the outgoing serial audio frame. Each accepted host read or write of a codec register becomes the contents of three outgoing slots: the 16-bit tag slot, the 20-bit command-address slot and the 20-bit command-data slot. Up to three codecs share the link. The primary codec is addressed through the tag's slot-valid bits. The secondary and tertiary codecs are addressed through a two-bit codec ID in the low tag bits, with those slot-valid bits cleared so that the primary codec ignores the access.

Only one access is in flight at a time. A busy flag rises on acceptance, and the host polls it before issuing the next access. Writes are posted: the host is told at once that the write is done, and busy stays high until the frame carrying the write has been taken. A read stays busy until the matching response arrives in the incoming status slots, or until a frame-count limit set at run time expires.

A per-codec copy of the most recent incoming slot 12 word lets reads of the slot 12 register offset finish without using the link. Host writes to that offset refresh the copy at once and are also sent as normal writes.

Top module: `ac_codec_regacc`

## Requirements
- R1: While a command is presented, `tx_cmd_addr` bit 19 is 1 for a read and 0 for a write. Bits 18:12 carry the register index `{req_addr[6:1],1'b0}`, and bits 11:0 are zero.
- R2: `tx_tag` bit 15 is 1 exactly while a command is presented, bits 12:2 are zero, and bits 1:0 hold the codec ID. Offsets 000h–07Fh give ID 00 (primary), 080h–0FFh give 01 (secondary) and 100h–17Fh give 10 (tertiary). A request to 180h–1FFh is ignored: busy stays low and no command and no done pulse appear.
- R3: A primary write sets tag bits 14 and 13, and `tx_cmd_data` = `{wdata,4'b0000}`.
- R4: A primary read sets tag bit 14, clears bit 13, and drives `tx_cmd_data` to zero.
- R5: A secondary or tertiary access clears tag bits 14 and 13. A write still carries `{wdata,4'b0000}` in `tx_cmd_data`.
- R6: `busy` rises in the cycle after a request is accepted. A request made while `busy` is high is ignored and leaves the presented slots unchanged.
- R7: An accepted write pulses `wr_done` for one cycle, in the cycle after acceptance, while `busy` is still high. `busy` falls in the cycle after the first `frame_start` that takes the write.
- R8: A presented command is held stable until a `frame_start`, is withdrawn in the cycle after it (`tx_tag` = 0), and is never presented again.
- R9: After its frame is taken, a read ends on the first `rx_valid` frame that has `rx_tag` bits 14 and 13 set and `rx_slot1[18:12]` equal to the index sent. In the next cycle, `rd_done` pulses with `rd_data` = `rx_slot2[19:4]` and `rd_timeout` = 0, and `busy` is low.
- R10: If `tmo_frames` received frames pass without a match (a value of 0 acts as 1), the read ends with `rd_done` and `rd_timeout` both 1, `rd_data` = 0, and `busy` low in the next cycle.
- R11: An `rx_valid` frame with `rx_tag` bit 3 set stores `rx_slot12[19:4]` as the slot 12 copy of the codec given by `rx_tag[1:0]`. ID 11 is ignored. The copies reset to zero.
- R12: A read of low offset 54h in any codec range (054h, 0D4h, 154h) pulses `rd_done` in the next cycle with that codec's copy, presents no command and leaves `busy` low.
- R13: A write to low offset 54h is sent as a normal write and replaces that codec's copy at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 9 | Register offset, range picks the codec |
| req_wdata | input | 16 | Write data |
| tmo_frames | input | 8 | Read response limit in received frames |
| wr_done | output | 1 | Posted-write completion pulse |
| rd_done | output | 1 | Read completion pulse |
| rd_timeout | output | 1 | Read ended without a response (valid with rd_done) |
| rd_data | output | 16 | Read data (valid with rd_done) |
| busy | output | 1 | Access semaphore |
| frame_start | input | 1 | Frame builder takes the presented slots |
| tx_tag | output | 16 | Outgoing tag slot |
| tx_cmd_addr | output | 20 | Outgoing command-address slot |
| tx_cmd_data | output | 20 | Outgoing command-data slot |
| rx_valid | input | 1 | Incoming status frame strobe |
| rx_tag | input | 16 | Incoming tag slot |
| rx_slot1 | input | 20 | Incoming status-address slot |
| rx_slot2 | input | 20 | Incoming status-data slot |
| rx_slot12 | input | 20 | Incoming slot 12 |

## Verification
The bench checks the tag patterns that separate a primary access from a non-primary one. A design that left the slot-valid bits set for a secondary codec would make the primary codec act on that codec's register. It also checks that a request made while busy changes nothing, since a design that took it would overwrite a pending posted write. Read-response checks use a frame with the wrong index, which must not end the read, and the timeout boundary, where one frame too many or too few would either hang the link or cut a slow codec short. For the slot 12 copies, the bench checks that a capture tagged with the reserved ID 11 is dropped and that a fast read leaves `busy` low and presents no command.

// File: rtl/ac_regacc_pkg.sv
package ac_regacc_pkg;
  localparam int TAG_W  = 16;
  localparam int SLOT_W = 20;
  localparam int IDX_W  = 7;
  localparam int REG_W  = 16;
  localparam int PAD_W  = SLOT_W - REG_W;

  localparam int TAG_FRAME = 15;
  localparam int TAG_S1    = 14;
  localparam int TAG_S2    = 13;
  localparam int TAG_S12   = 3;

  typedef logic [1:0] codec_id_t;
  localparam codec_id_t CID_PRI = 2'b00;
  localparam codec_id_t CID_RSV = 2'b11;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WR_PEND = 2'd1,
    ST_RD_PEND = 2'd2,
    ST_RD_WAIT = 2'd3
  } acc_state_e;
endpackage

// File: rtl/acc_slot_shadow.sv
module acc_slot_shadow
  import ac_regacc_pkg::*;
#(
  parameter int NUM_CODECS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  codec_id_t        cap_codec,
  input  logic [REG_W-1:0] cap_data,
  input  logic             upd_en,
  input  codec_id_t        upd_codec,
  input  logic [REG_W-1:0] upd_data,
  input  codec_id_t        rd_codec,
  output logic [REG_W-1:0] rd_data
);
  logic [REG_W-1:0] copy_q [NUM_CODECS];
  logic [REG_W-1:0] copy_d [NUM_CODECS];

  for (genvar gi = 0; gi < NUM_CODECS; gi++) begin : g_copy
    localparam codec_id_t MY_ID = codec_id_t'(gi);

    // host write wins over a same-cycle capture
    always_comb begin
      copy_d[gi] = copy_q[gi];
      if (upd_en && (upd_codec == MY_ID)) begin
        copy_d[gi] = upd_data;
      end else if (cap_en && (cap_codec == MY_ID)) begin
        copy_d[gi] = cap_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        copy_q[gi] <= '0;
      end else begin
        copy_q[gi] <= copy_d[gi];
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_CODECS; i++) begin
      if (rd_codec == codec_id_t'(i)) begin
        rd_data = copy_q[i];
      end
    end
  end
endmodule

// File: rtl/acc_slot_build.sv
module acc_slot_build
  import ac_regacc_pkg::*;
(
  input  logic              cmd_present,
  input  logic              cmd_write,
  input  codec_id_t         cmd_codec,
  input  logic [IDX_W-1:0]  cmd_index,
  input  logic [REG_W-1:0]  cmd_data,
  output logic [TAG_W-1:0]  tx_tag,
  output logic [SLOT_W-1:0] tx_cmd_addr,
  output logic [SLOT_W-1:0] tx_cmd_data
);
  localparam int ADDR_PAD = SLOT_W - 1 - IDX_W;

  logic is_primary;

  always_comb begin
    is_primary  = (cmd_codec == CID_PRI);
    tx_tag      = '0;
    tx_cmd_addr = '0;
    tx_cmd_data = '0;
    if (cmd_present) begin
      tx_tag[TAG_FRAME] = 1'b1;
      tx_tag[TAG_S1]    = is_primary;
      tx_tag[TAG_S2]    = is_primary && cmd_write;
      tx_tag[1:0]       = cmd_codec;
      tx_cmd_addr       = {~cmd_write, cmd_index, {ADDR_PAD{1'b0}}};
      if (cmd_write) begin
        tx_cmd_data = {cmd_data, {PAD_W{1'b0}}};
      end
    end
  end
endmodule

// File: rtl/acc_cmd_fsm.sv
module acc_cmd_fsm
  import ac_regacc_pkg::*;
#(
  parameter int          ADDR_W     = 9,
  parameter int          TMO_W      = 8,
  parameter logic [6:0]  SHADOW_OFS = 7'h54
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [REG_W-1:0]  req_wdata,
  input  logic [TMO_W-1:0]  tmo_frames,
  input  logic              frame_start,
  input  logic              rx_valid,
  input  logic              rx_s1_valid,
  input  logic              rx_s2_valid,
  input  logic [IDX_W-1:0]  rx_index,
  input  logic [REG_W-1:0]  rx_data,
  input  logic [REG_W-1:0]  shadow_rdata,
  output codec_id_t         req_codec,
  output logic              shadow_upd,
  output logic              busy,
  output logic              cmd_present,
  output logic              cmd_write,
  output codec_id_t         cmd_codec,
  output logic [IDX_W-1:0]  cmd_index,
  output logic [REG_W-1:0]  cmd_data,
  output logic              wr_done,
  output logic              rd_done,
  output logic              rd_timeout,
  output logic [REG_W-1:0]  rd_data
);
  localparam int CNT_W = TMO_W + 1;

  acc_state_e       state_q, state_d;
  logic             wr_q, wr_d;
  codec_id_t        cid_q, cid_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [REG_W-1:0] dat_q, dat_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wr_done_q, wr_done_d;
  logic             rd_done_q, rd_done_d;
  logic             rd_tmo_q, rd_tmo_d;
  logic [REG_W-1:0] rd_data_q, rd_data_d;

  logic legal, accept, is_shadow, fast_rd, resp_match, tmo_hit;

  always_comb begin
    req_codec  = codec_id_t'(req_addr[ADDR_W-1 -: 2]);
    legal      = (req_codec != CID_RSV);
    is_shadow  = (req_addr[6:0] == SHADOW_OFS);
    accept     = req_valid && legal && (state_q == ST_IDLE);
    fast_rd    = accept && !req_write && is_shadow;
    shadow_upd = accept && req_write && is_shadow;
    resp_match = rx_valid && rx_s1_valid && rx_s2_valid && (rx_index == idx_q);
    tmo_hit    = (cnt_q + CNT_W'(1)) >= {1'b0, tmo_frames};
  end

  always_comb begin
    state_d   = state_q;
    wr_d      = wr_q;
    cid_d     = cid_q;
    idx_d     = idx_q;
    dat_d     = dat_q;
    cnt_d     = cnt_q;
    wr_done_d = 1'b0;
    rd_done_d = 1'b0;
    rd_tmo_d  = 1'b0;
    rd_data_d = rd_data_q;
    unique case (state_q)
      ST_IDLE: begin
        if (fast_rd) begin
          rd_done_d = 1'b1;
          rd_data_d = shadow_rdata;
        end else if (accept) begin
          wr_d      = req_write;
          cid_d     = req_codec;
          idx_d     = {req_addr[6:1], 1'b0};
          dat_d     = req_write ? req_wdata : '0;
          wr_done_d = req_write;
          state_d   = req_write ? ST_WR_PEND : ST_RD_PEND;
        end
      end
      ST_WR_PEND: begin
        if (frame_start) begin
          state_d = ST_IDLE;
        end
      end
      ST_RD_PEND: begin
        if (frame_start) begin
          cnt_d   = '0;
          state_d = ST_RD_WAIT;
        end
      end
      ST_RD_WAIT: begin
        if (resp_match) begin
          rd_done_d = 1'b1;
          rd_data_d = rx_data;
          state_d   = ST_IDLE;
        end else if (rx_valid) begin
          if (tmo_hit) begin
            rd_done_d = 1'b1;
            rd_tmo_d  = 1'b1;
            rd_data_d = '0;
            state_d   = ST_IDLE;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      wr_q      <= 1'b0;
      cid_q     <= CID_PRI;
      idx_q     <= '0;
      dat_q     <= '0;
      cnt_q     <= '0;
      wr_done_q <= 1'b0;
      rd_done_q <= 1'b0;
      rd_tmo_q  <= 1'b0;
      rd_data_q <= '0;
    end else begin
      state_q   <= state_d;
      wr_q      <= wr_d;
      cid_q     <= cid_d;
      idx_q     <= idx_d;
      dat_q     <= dat_d;
      cnt_q     <= cnt_d;
      wr_done_q <= wr_done_d;
      rd_done_q <= rd_done_d;
      rd_tmo_q  <= rd_tmo_d;
      rd_data_q <= rd_data_d;
    end
  end

  always_comb begin
    busy        = (state_q != ST_IDLE);
    cmd_present = (state_q == ST_WR_PEND) || (state_q == ST_RD_PEND);
    cmd_write   = wr_q;
    cmd_codec   = cid_q;
    cmd_index   = idx_q;
    cmd_data    = dat_q;
    wr_done     = wr_done_q;
    rd_done     = rd_done_q;
    rd_timeout  = rd_tmo_q;
    rd_data     = rd_data_q;
  end
endmodule

// File: rtl/ac_codec_regacc.sv
module ac_codec_regacc
  import ac_regacc_pkg::*;
#(
  parameter int         ADDR_W     = 9,
  parameter int         TMO_W      = 8,
  parameter int         NUM_CODECS = 3,
  parameter logic [6:0] SHADOW_OFS = 7'h54
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  input  logic [TMO_W-1:0]  tmo_frames,
  output logic              wr_done,
  output logic              rd_done,
  output logic              rd_timeout,
  output logic [15:0]       rd_data,
  output logic              busy,
  input  logic              frame_start,
  output logic [15:0]       tx_tag,
  output logic [19:0]       tx_cmd_addr,
  output logic [19:0]       tx_cmd_data,
  input  logic              rx_valid,
  input  logic [15:0]       rx_tag,
  input  logic [19:0]       rx_slot1,
  input  logic [19:0]       rx_slot2,
  input  logic [19:0]       rx_slot12
);
  codec_id_t        req_codec;
  logic             shadow_upd;
  logic [REG_W-1:0] shadow_rdata;
  logic             cmd_present, cmd_write;
  codec_id_t        cmd_codec;
  logic [IDX_W-1:0] cmd_index;
  logic [REG_W-1:0] cmd_data;
  logic             cap_en;

  logic unused_bits;
  assign unused_bits = ^{req_addr[0], rx_tag[12:4], rx_tag[2], rx_tag[15],
                         rx_slot1[19], rx_slot1[11:0], rx_slot2[3:0], rx_slot12[3:0]};

  assign cap_en = rx_valid && rx_tag[TAG_S12];

  acc_cmd_fsm #(
    .ADDR_W(ADDR_W), .TMO_W(TMO_W), .SHADOW_OFS(SHADOW_OFS)
  ) fsm_i (
    .clk, .rst_n, .req_valid, .req_write, .req_addr, .req_wdata, .tmo_frames,
    .frame_start, .rx_valid,
    .rx_s1_valid (rx_tag[TAG_S1]),
    .rx_s2_valid (rx_tag[TAG_S2]),
    .rx_index    (rx_slot1[18:12]),
    .rx_data     (rx_slot2[19:4]),
    .shadow_rdata, .req_codec, .shadow_upd, .busy,
    .cmd_present, .cmd_write, .cmd_codec, .cmd_index, .cmd_data,
    .wr_done, .rd_done, .rd_timeout, .rd_data
  );

  acc_slot_shadow #(.NUM_CODECS(NUM_CODECS)) shadow_i (
    .clk, .rst_n,
    .cap_en,
    .cap_codec (codec_id_t'(rx_tag[1:0])),
    .cap_data  (rx_slot12[19:4]),
    .upd_en    (shadow_upd),
    .upd_codec (req_codec),
    .upd_data  (req_wdata),
    .rd_codec  (req_codec),
    .rd_data   (shadow_rdata)
  );

  acc_slot_build build_i (
    .cmd_present, .cmd_write, .cmd_codec, .cmd_index, .cmd_data,
    .tx_tag, .tx_cmd_addr, .tx_cmd_data
  );
endmodule

// File: rtl/ac_codec_regacc_chk.sv
module ac_codec_regacc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        busy,
  input logic        frame_start,
  input logic        wr_done,
  input logic        rd_done,
  input logic [15:0] tx_tag,
  input logic [19:0] tx_cmd_addr,
  input logic [19:0] tx_cmd_data
);
  // R2: a presented command always has a legal codec ID and clean reserved bits
  a_r2_tag_fields: assert property (@(posedge clk) disable iff (!rst_n)
    tx_tag[15] |-> (tx_tag[1:0] != 2'b11) && (tx_tag[12:2] == '0));

  // R3: primary write marks both command slots valid
  a_r3_pri_write: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_tag[15] && !tx_cmd_addr[19] && tx_tag[1:0] == 2'b00) |-> (tx_tag[14] && tx_tag[13]));

  // R4: primary read marks only slot 1 and sends no data
  a_r4_pri_read: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_tag[15] && tx_cmd_addr[19] && tx_tag[1:0] == 2'b00)
      |-> (tx_tag[14] && !tx_tag[13] && tx_cmd_data == '0));

  // R5: non-primary accesses leave the slot-valid bits clear
  a_r5_nonpri: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_tag[15] && tx_tag[1:0] != 2'b00) |-> (!tx_tag[14] && !tx_tag[13]));

  // R6: a command is presented only while busy
  a_r6_busy_cover: assert property (@(posedge clk) disable iff (!rst_n)
    tx_tag[15] |-> busy);

  // R6: no write is posted from a request made while busy
  a_r6_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> !wr_done);

  // R8: the command is held until taken
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_tag[15] && !frame_start)
      |=> ($stable(tx_tag) && $stable(tx_cmd_addr) && $stable(tx_cmd_data)));

  // R8: the command is sent exactly once
  a_r8_once: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_tag[15] && frame_start) |=> !tx_tag[15]);

  // R9: a read completion leaves the semaphore free
  a_r9_done_free: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> !busy);

  a_r7_single_done: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_done, rd_done}));
endmodule

bind ac_codec_regacc ac_codec_regacc_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy),
  .frame_start(frame_start), .wr_done(wr_done), .rd_done(rd_done),
  .tx_tag(tx_tag), .tx_cmd_addr(tx_cmd_addr), .tx_cmd_data(tx_cmd_data)
);

// File: tb/ac_codec_regacc_tb_top.sv
module ac_codec_regacc_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [8:0]  req_addr;
  logic [15:0] req_wdata;
  logic [7:0]  tmo_frames;
  logic        wr_done, rd_done, rd_timeout, busy;
  logic [15:0] rd_data;
  logic        frame_start;
  logic [15:0] tx_tag;
  logic [19:0] tx_cmd_addr, tx_cmd_data;
  logic        rx_valid;
  logic [15:0] rx_tag;
  logic [19:0] rx_slot1, rx_slot2, rx_slot12;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ac_codec_regacc dut_i (
    .clk, .rst_n, .req_valid, .req_write, .req_addr, .req_wdata, .tmo_frames,
    .wr_done, .rd_done, .rd_timeout, .rd_data, .busy, .frame_start,
    .tx_tag, .tx_cmd_addr, .tx_cmd_data,
    .rx_valid, .rx_tag, .rx_slot1, .rx_slot2, .rx_slot12
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    check(act === exp, req, act, exp);
  endtask

  // one clock with the given pulses; outputs sampled at the following negedge
  task automatic step();
    @(negedge clk);
    req_valid = 0; frame_start = 0; rx_valid = 0;
  endtask

  task automatic request(input bit wr, input logic [8:0] a, input logic [15:0] d);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    step();
  endtask

  task automatic send_frame();
    frame_start = 1;
    step();
  endtask

  task automatic rx_frame(input logic [15:0] tg, input logic [19:0] s1,
                          input logic [19:0] s2, input logic [19:0] s12);
    rx_valid = 1; rx_tag = tg; rx_slot1 = s1; rx_slot2 = s2; rx_slot12 = s12;
    step();
  endtask

  task automatic t_reset();
    chk_eq("R6 reset busy", busy, 0);
    chk_eq("R2 reset tag", tx_tag, 0);
    chk_eq("R9 reset rd_done", rd_done, 0);
  endtask

  task automatic t_primary_write();
    request(1, 9'h02E, 16'hBEEF);
    chk_eq("R6 busy after accept", busy, 1);
    chk_eq("R7 wr_done posted", wr_done, 1);
    chk_eq("R3 tag", tx_tag, 16'hE000);
    chk_eq("R1 addr slot", tx_cmd_addr, 20'h2E000);
    chk_eq("R3 data slot", tx_cmd_data, 20'hBEEF0);
    request(0, 9'h010, 16'h0);
    chk_eq("R6 busy request ignored", tx_cmd_addr, 20'h2E000);
    chk_eq("R7 single pulse", wr_done, 0);
    send_frame();
    chk_eq("R7 busy clears after frame", busy, 0);
    chk_eq("R8 withdrawn", tx_tag, 0);
    step();
    chk_eq("R8 not resent", tx_tag, 0);
  endtask

  task automatic t_primary_read();
    tmo_frames = 8'd4;
    request(0, 9'h07D, 16'h0);
    chk_eq("R4 tag", tx_tag, 16'hC000);
    chk_eq("R1 read addr slot", tx_cmd_addr, 20'hFC000);
    chk_eq("R4 data slot zero", tx_cmd_data, 0);
    send_frame();
    chk_eq("R8 read withdrawn", tx_tag, 0);
    chk_eq("R9 busy while waiting", busy, 1);
    rx_frame(16'hE000, 20'h12000, 20'h99990, 0);
    chk_eq("R9 wrong index ignored", busy, 1);
    rx_frame(16'hE000, 20'h7C000, 20'h12340, 0);
    chk_eq("R9 rd_done", rd_done, 1);
    chk_eq("R9 rd_data", rd_data, 16'h1234);
    chk_eq("R9 no timeout", rd_timeout, 0);
    chk_eq("R9 busy clear", busy, 0);
  endtask

  task automatic t_secondary_write();
    request(1, 9'h0A6, 16'h5555);
    chk_eq("R5 sec tag", tx_tag, 16'h8001);
    chk_eq("R2 sec addr", tx_cmd_addr, 20'h26000);
    chk_eq("R5 sec data", tx_cmd_data, 20'h55550);
    send_frame();
    chk_eq("R7 sec busy clear", busy, 0);
  endtask

  task automatic t_tertiary_timeout();
    tmo_frames = 8'd3;
    request(0, 9'h11A, 16'h0);
    chk_eq("R2 ter tag", tx_tag, 16'h8002);
    chk_eq("R1 ter addr", tx_cmd_addr, 20'h9A000);
    send_frame();
    rx_frame(0, 0, 0, 0);
    rx_frame(0, 0, 0, 0);
    chk_eq("R10 still waiting", busy, 1);
    chk_eq("R10 no early done", rd_done, 0);
    rx_frame(0, 0, 0, 0);
    chk_eq("R10 done on limit", rd_done, 1);
    chk_eq("R10 timeout flag", rd_timeout, 1);
    chk_eq("R10 data zero", rd_data, 0);
    chk_eq("R10 busy clear", busy, 0);
    tmo_frames = 8'd0;
    request(0, 9'h004, 16'h0);
    send_frame();
    rx_frame(0, 0, 0, 0);
    chk_eq("R10 zero limit acts as one", {rd_done, rd_timeout}, 2'b11);
  endtask

  task automatic t_illegal();
    request(1, 9'h190, 16'h1111);
    chk_eq("R2 illegal busy", busy, 0);
    chk_eq("R2 illegal tag", tx_tag, 0);
    chk_eq("R2 illegal no done", wr_done, 0);
  endtask

  task automatic t_shadow();
    rx_frame(16'h000A, 0, 0, 20'hABCD0);
    rx_frame(16'h000B, 0, 0, 20'h11110);
    request(0, 9'h154, 16'h0);
    chk_eq("R12 fast done", rd_done, 1);
    chk_eq("R11 R12 fast data", rd_data, 16'hABCD);
    chk_eq("R12 no busy", busy, 0);
    chk_eq("R12 no command", tx_tag, 0);
    request(0, 9'h054, 16'h0);
    chk_eq("R11 primary copy untouched", rd_data, 16'h0000);
    request(1, 9'h0D4, 16'h7777);
    chk_eq("R13 sent as write", tx_tag, 16'h8001);
    chk_eq("R13 write addr", tx_cmd_addr, 20'h54000);
    send_frame();
    request(0, 9'h0D4, 16'h0);
    chk_eq("R13 copy updated", rd_data, 16'h7777);
  endtask

  initial begin
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0;
    tmo_frames = 8'd4; frame_start = 0; rx_valid = 0; rx_tag = 0;
    rx_slot1 = 0; rx_slot2 = 0; rx_slot12 = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_primary_write();
    t_primary_read();
    t_secondary_write();
    t_tertiary_timeout();
    t_illegal();
    t_shadow();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule